// File: doc/BRIEF.md
# Speculation-Aware Line Directory

This block is the memory-side directory for a two-level cache hierarchy. It tracks, for a few lines at a time, whether the memory copy is valid or a single cache owns a possibly modified copy. It serves three kinds of read request: an ordinary fetch, a speculative fetch issued for a load that may later be squashed, and an expose that confirms an earlier speculative load. A speculative fetch returns data without recording any owner, so the line stays uncached as far as the directory is concerned. An expose returns data and makes the requestor the owner.

Each read sent to memory is tagged with the requestor, an origin field, an index field and a 2-bit kind code. Memory answers with the requestor identifier echoed. A request that meets a line in the middle of a transaction is parked in a small shared hold buffer. It is replayed, oldest first, once the memory reply that closes the transaction arrives. A request that meets an owned line triggers an invalidate to the owner and is held until the owner writes the line back.

The directory handles one event per cycle. A memory reply always wins that slot, then a replay, then a new request.

Top module: `spec_dir`

## Requirements
- R1: After reset all output strobes are low and `req_ready` is high.
- R2: Request type codes are 0 fetch, 1 speculative fetch, 2 expose, 3 writeback. A fetch to an untracked line produces, one cycle after acceptance, a memory read carrying the request's address, requestor, origin and index with kind 0.
- R3: A speculative fetch to an untracked line issues a read with kind 1. Its memory data yields a response with kind 1 and dirty low to the echoed requestor, and the line is left untracked, so a following fetch goes to memory again.
- R4: An expose to an untracked line issues a read with kind 2. Its memory data yields a response with kind 2 and dirty low, and makes the requestor the owner, so a following fetch invalidates that requestor.
- R5: Memory data for an ordinary fetch yields a response with kind 0 and dirty low to the echoed requestor, and makes it the owner.
- R6: A fetch, speculative fetch or expose to an owned line sends an invalidate with the line address to the owner, issues no memory read, and holds the request.
- R7: A writeback to an owned line issues a memory write of its data. The memory acknowledge for that line makes it untracked and releases the held requests, which replay in the following cycles.
- R8: While a line awaits memory, every request to it, writebacks included, is held with no memory operation. Held requests are released when the memory reply for that line arrives.
- R9: Held requests of one line are processed in arrival order. A new non-writeback request to a line that already has held requests queues behind them without any further invalidate.
- R10: `req_ready` is low in any cycle where `mem_rsp_valid` is high. A memory reply that matches no waiting line has no effect.
- R11: `req_ready` is low when the hold buffer is full, or when the request addresses an untracked line and every table entry is in use.
- R12: A writeback to an untracked line is consumed with no memory write and no response.
- R13: A request to one line proceeds while another line has held requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_type | input | 2 | 0 fetch, 1 speculative fetch, 2 expose, 3 writeback |
| req_addr | input | ADDR_W | Line address |
| req_src | input | SRC_W | Requestor identifier |
| req_origin | input | ORIG_W | Origin tag forwarded to memory |
| req_idx | input | IDX_W | Index tag forwarded to memory |
| req_data | input | DATA_W | Writeback data |
| mem_rd_valid | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W | Read address |
| mem_rd_src | output | SRC_W | Requestor tag |
| mem_rd_origin | output | ORIG_W | Origin tag |
| mem_rd_idx | output | IDX_W | Index tag |
| mem_rd_kind | output | 2 | 0 normal, 1 speculative, 2 expose |
| mem_wr_valid | output | 1 | Memory write strobe |
| mem_wr_addr | output | ADDR_W | Write address |
| mem_wr_data | output | DATA_W | Write data |
| mem_rsp_valid | input | 1 | Memory reply present |
| mem_rsp_ack | input | 1 | 1 write acknowledge, 0 read data |
| mem_rsp_addr | input | ADDR_W | Reply address |
| mem_rsp_src | input | SRC_W | Echoed requestor |
| mem_rsp_data | input | DATA_W | Read data |
| rsp_valid | output | 1 | Data response strobe |
| rsp_dst | output | SRC_W | Response destination |
| rsp_addr | output | ADDR_W | Response address |
| rsp_data | output | DATA_W | Response data |
| rsp_kind | output | 2 | Path that produced the response |
| rsp_dirty | output | 1 | Dirty flag, always low |
| inv_valid | output | 1 | Invalidate strobe |
| inv_dst | output | SRC_W | Owner to invalidate |
| inv_addr | output | ADDR_W | Line to invalidate |

## Verification
Several invariants are checked on every cycle: that read kind codes are legal, that at most one output strobe fires per cycle, and that a data response only follows a memory data reply. The per-line held counts must always sum to the hold buffer's occupancy, and no line may occupy two table entries. Other behaviours can only be shown by the directed scenarios. These include which path produced a response, that a speculative fetch leaves no owner while an expose records one, the replay order after a wakeup, that traffic to one line continues while another is held, and the back-pressure cases when the buffer or table is full.

// File: rtl/spec_dir.sv
module spec_dir #(
  parameter int ADDR_W = 16,
  parameter int SRC_W  = 3,
  parameter int ORIG_W = 3,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32,
  parameter int LINES  = 8,
  parameter int SDEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_type,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [ORIG_W-1:0] req_origin,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [DATA_W-1:0] req_data,
  output logic              mem_rd_valid,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic [SRC_W-1:0]  mem_rd_src,
  output logic [ORIG_W-1:0] mem_rd_origin,
  output logic [IDX_W-1:0]  mem_rd_idx,
  output logic [1:0]        mem_rd_kind,
  output logic              mem_wr_valid,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_ack,
  input  logic [ADDR_W-1:0] mem_rsp_addr,
  input  logic [SRC_W-1:0]  mem_rsp_src,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              rsp_valid,
  output logic [SRC_W-1:0]  rsp_dst,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_data,
  output logic [1:0]        rsp_kind,
  output logic              rsp_dirty,
  output logic              inv_valid,
  output logic [SRC_W-1:0]  inv_dst,
  output logic [ADDR_W-1:0] inv_addr
);

  localparam int LW = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int SW = (SDEPTH > 1) ? $clog2(SDEPTH) : 1;
  localparam int CW = $clog2(SDEPTH + 1);

  localparam logic [1:0] T_GET = 2'd0, T_SPEC = 2'd1, T_EXP = 2'd2, T_WB = 2'd3;

  typedef enum logic [2:0] {S_I, S_M, S_IM, S_IE, S_II, S_MI} lst_t;

  typedef struct packed {
    logic [1:0]        ty;
    logic [ADDR_W-1:0] addr;
    logic [SRC_W-1:0]  src;
    logic [ORIG_W-1:0] origin;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] data;
  } rq_t;

  lst_t              t_st  [LINES];
  logic [ADDR_W-1:0] t_tag [LINES];
  logic [SRC_W-1:0]  t_own [LINES];
  logic [CW-1:0]     t_cnt [LINES];

  rq_t               b_rq  [SDEPTH];
  logic [SDEPTH-1:0] b_vld, b_rdy;

  logic              rp_hit;
  logic [SW-1:0]     rp_sel;
  logic              use_rep, go_new, go_req, buf_full;
  rq_t               cur;
  logic [ADDR_W-1:0] lk_addr;
  logic              hit, free_any;
  logic [LW-1:0]     hit_idx, free_idx, idx;
  lst_t              cst, nst;
  logic [CW-1:0]     ccnt, occ;
  logic              act_rd, act_wr, act_inv, act_stall, mem_ok;
  logic [1:0]        rd_kind;

  always_comb begin
    rp_hit = 1'b0;
    rp_sel = '0;
    for (int i = 0; i < SDEPTH; i++)
      if (b_vld[i] && b_rdy[i] && !rp_hit) begin
        rp_hit = 1'b1;
        rp_sel = SW'(i);
      end
  end

  assign use_rep  = !mem_rsp_valid && rp_hit;
  assign buf_full = b_vld[SDEPTH-1];
  assign occ      = CW'($countones(b_vld));
  assign cur      = use_rep ? b_rq[rp_sel]
                            : rq_t'{ty: req_type, addr: req_addr, src: req_src,
                                    origin: req_origin, idx: req_idx, data: req_data};
  assign lk_addr  = mem_rsp_valid ? mem_rsp_addr : cur.addr;

  always_comb begin
    hit = 1'b0; hit_idx = '0; free_any = 1'b0; free_idx = '0;
    for (int i = 0; i < LINES; i++) begin
      if ((t_st[i] != S_I || t_cnt[i] != '0) && t_tag[i] == lk_addr && !hit) begin
        hit = 1'b1;
        hit_idx = LW'(i);
      end
      if (t_st[i] == S_I && t_cnt[i] == '0 && !free_any) begin
        free_any = 1'b1;
        free_idx = LW'(i);
      end
    end
  end

  assign idx       = hit ? hit_idx : free_idx;
  assign cst       = hit ? t_st[hit_idx] : S_I;
  assign ccnt      = hit ? t_cnt[hit_idx] : '0;
  assign req_ready = !mem_rsp_valid && !rp_hit && !buf_full && (hit || free_any);
  assign go_new    = req_valid && req_ready;
  assign go_req    = use_rep || go_new;
  assign rsp_dirty = 1'b0;

  always_comb begin
    act_rd = 1'b0; act_wr = 1'b0; act_inv = 1'b0; act_stall = 1'b0;
    rd_kind = 2'd0; nst = cst;
    if (go_req) begin
      if (go_new && ccnt != '0 && cur.ty != T_WB) act_stall = 1'b1;
      else begin
        case (cst)
          S_I: begin
            case (cur.ty)
              T_GET:  begin nst = S_IM; act_rd = 1'b1; rd_kind = 2'd0; end
              T_SPEC: begin nst = S_II; act_rd = 1'b1; rd_kind = 2'd1; end
              T_EXP:  begin nst = S_IE; act_rd = 1'b1; rd_kind = 2'd2; end
              default: ;
            endcase
          end
          S_M: begin
            if (cur.ty == T_WB) begin nst = S_MI; act_wr = 1'b1; end
            else begin act_inv = 1'b1; act_stall = 1'b1; end
          end
          default: act_stall = 1'b1;
        endcase
      end
    end
  end

  assign mem_ok = mem_rsp_valid && hit &&
                  ((!mem_rsp_ack && (cst == S_IM || cst == S_IE || cst == S_II)) ||
                   (mem_rsp_ack && cst == S_MI));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        t_st[i] <= S_I; t_tag[i] <= '0; t_own[i] <= '0; t_cnt[i] <= '0;
      end
      for (int j = 0; j < SDEPTH; j++) b_rq[j] <= '0;
      b_vld <= '0; b_rdy <= '0;
      mem_rd_valid <= 1'b0; mem_rd_addr <= '0; mem_rd_src <= '0;
      mem_rd_origin <= '0; mem_rd_idx <= '0; mem_rd_kind <= '0;
      mem_wr_valid <= 1'b0; mem_wr_addr <= '0; mem_wr_data <= '0;
      rsp_valid <= 1'b0; rsp_dst <= '0; rsp_addr <= '0; rsp_data <= '0; rsp_kind <= '0;
      inv_valid <= 1'b0; inv_dst <= '0; inv_addr <= '0;
    end else begin
      mem_rd_valid <= 1'b0;
      mem_wr_valid <= 1'b0;
      rsp_valid    <= 1'b0;
      inv_valid    <= 1'b0;
      if (mem_ok) begin
        rsp_valid <= !mem_rsp_ack;
        rsp_dst   <= mem_rsp_src;
        rsp_addr  <= mem_rsp_addr;
        rsp_data  <= mem_rsp_data;
        case (cst)
          S_IM: begin t_st[idx] <= S_M; t_own[idx] <= mem_rsp_src; rsp_kind <= 2'd0; end
          S_IE: begin t_st[idx] <= S_M; t_own[idx] <= mem_rsp_src; rsp_kind <= 2'd2; end
          S_II: begin t_st[idx] <= S_I; rsp_kind <= 2'd1; end
          default: t_st[idx] <= S_I;
        endcase
        for (int j = 0; j < SDEPTH; j++)
          if (b_vld[j] && b_rq[j].addr == mem_rsp_addr) b_rdy[j] <= 1'b1;
      end else if (go_req) begin
        t_tag[idx]    <= cur.addr;
        t_st[idx]     <= nst;
        mem_rd_valid  <= act_rd;
        mem_rd_addr   <= cur.addr;
        mem_rd_src    <= cur.src;
        mem_rd_origin <= cur.origin;
        mem_rd_idx    <= cur.idx;
        mem_rd_kind   <= rd_kind;
        mem_wr_valid  <= act_wr;
        mem_wr_addr   <= cur.addr;
        mem_wr_data   <= cur.data;
        inv_valid     <= act_inv;
        inv_dst       <= t_own[idx];
        inv_addr      <= cur.addr;
        if (use_rep) begin
          if (act_stall) b_rdy[rp_sel] <= 1'b0;
          else begin
            for (int j = 0; j < SDEPTH - 1; j++)
              if (j >= int'(rp_sel)) begin
                b_rq[j]  <= b_rq[j+1];
                b_vld[j] <= b_vld[j+1];
                b_rdy[j] <= b_rdy[j+1];
              end
            b_vld[SDEPTH-1] <= 1'b0;
            b_rdy[SDEPTH-1] <= 1'b0;
            t_cnt[idx] <= ccnt - CW'(1);
          end
        end else if (act_stall) begin
          b_rq[occ[SW-1:0]]  <= cur;
          b_vld[occ[SW-1:0]] <= 1'b1;
          b_rdy[occ[SW-1:0]] <= 1'b0;
          t_cnt[idx] <= ccnt + CW'(1);
        end
      end
    end
  end

  logic [CW+LW:0] cnt_sum;
  logic           dup_line;
  always_comb begin
    cnt_sum  = '0;
    dup_line = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      cnt_sum = cnt_sum + (CW+LW+1)'(t_cnt[i]);
      for (int k = i + 1; k < LINES; k++)
        if ((t_st[i] != S_I || t_cnt[i] != '0) && (t_st[k] != S_I || t_cnt[k] != '0) &&
            t_tag[i] == t_tag[k]) dup_line = 1'b1;
    end
  end

  a_r2_rd_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> mem_rd_kind != 2'd3);
  a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mem_rd_valid, mem_wr_valid, inv_valid, rsp_valid}) <= 1);
  a_r5_rsp_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(mem_rsp_valid) && !$past(mem_rsp_ack)));
  a_r9_count_match: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_sum) == $countones(b_vld));
  a_r11_one_entry_per_line: assert property (@(posedge clk) disable iff (!rst_n)
    !dup_line);

endmodule

// File: tb/spec_dir_test.sv
module spec_dir_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [1:0]  req_type = '0;
  logic [15:0] req_addr = '0;
  logic [2:0]  req_src = '0, req_origin = '0;
  logic [3:0]  req_idx = '0;
  logic [31:0] req_data = '0;
  logic        mem_rd_valid, mem_wr_valid, rsp_valid, rsp_dirty, inv_valid;
  logic [15:0] mem_rd_addr, mem_wr_addr, rsp_addr, inv_addr;
  logic [2:0]  mem_rd_src, mem_rd_origin, rsp_dst, inv_dst;
  logic [3:0]  mem_rd_idx;
  logic [1:0]  mem_rd_kind, rsp_kind;
  logic [31:0] mem_wr_data, rsp_data;
  logic        mem_rsp_valid = 1'b0, mem_rsp_ack = 1'b0;
  logic [15:0] mem_rsp_addr = '0;
  logic [2:0]  mem_rsp_src = '0;
  logic [31:0] mem_rsp_data = '0;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  spec_dir uut (.*);

  task automatic check(string r, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0; mem_rsp_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic send(logic [1:0] ty, logic [15:0] a, logic [2:0] s,
                      logic [2:0] o = 3'd0, logic [3:0] ix = 4'd0, logic [31:0] d = 32'd0);
    @(negedge clk);
    req_type = ty; req_addr = a; req_src = s; req_origin = o; req_idx = ix; req_data = d;
    req_valid = 1'b1;
    forever begin
      #1;
      if (req_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic mem(logic ack, logic [15:0] a, logic [2:0] s, logic [31:0] d = 32'd0);
    @(negedge clk);
    mem_rsp_valid = 1'b1; mem_rsp_ack = ack; mem_rsp_addr = a; mem_rsp_src = s; mem_rsp_data = d;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
  endtask

  task automatic quiet(string r);
    check(r, {mem_rd_valid, mem_wr_valid, rsp_valid, inv_valid}, 4'b0000);
  endtask

  task automatic exp_rd(string r, logic [15:0] a, logic [2:0] s, logic [1:0] k);
    check(r, {mem_rd_valid, mem_rd_addr, mem_rd_src, mem_rd_kind}, {1'b1, a, s, k});
  endtask

  task automatic exp_rsp(string r, logic [15:0] a, logic [2:0] s, logic [1:0] k, logic [31:0] d);
    check(r, {rsp_valid, rsp_addr, rsp_dst, rsp_kind, rsp_dirty, rsp_data}, {1'b1, a, s, k, 1'b0, d});
  endtask

  task automatic exp_inv(string r, logic [15:0] a, logic [2:0] s);
    check(r, {inv_valid, inv_addr, inv_dst, mem_rd_valid}, {1'b1, a, s, 1'b0});
  endtask

  task automatic exp_wr(string r, logic [15:0] a, logic [31:0] d);
    check(r, {mem_wr_valid, mem_wr_addr, mem_wr_data}, {1'b1, a, d});
  endtask

  task automatic t_reset();
    do_reset();
    quiet("R1");
    check("R1 ready", req_ready, 1'b1);
  endtask

  task automatic t_owned_line();
    send(0, 16'h0100, 3'd3, 3'd5, 4'd7);
    exp_rd("R2", 16'h0100, 3'd3, 2'd0);
    check("R2 tags", {mem_rd_origin, mem_rd_idx}, {3'd5, 4'd7});
    mem(0, 16'h0100, 3'd3, 32'hA1);
    exp_rsp("R5", 16'h0100, 3'd3, 2'd0, 32'hA1);
    send(0, 16'h0100, 3'd1);
    exp_inv("R6", 16'h0100, 3'd3);
    send(1, 16'h0100, 3'd2);
    quiet("R9 queued behind");
    send(3, 16'h0100, 3'd3, 3'd0, 4'd0, 32'hD3);
    exp_wr("R7 write", 16'h0100, 32'hD3);
    mem(1, 16'h0100, 3'd3);
    quiet("R7 ack");
    @(negedge clk);
    exp_rd("R9 first replay", 16'h0100, 3'd1, 2'd0);
    @(negedge clk);
    quiet("R8 second held");
    mem(0, 16'h0100, 3'd1, 32'hB2);
    exp_rsp("R5 replayed", 16'h0100, 3'd1, 2'd0, 32'hB2);
    @(negedge clk);
    exp_inv("R6 replay in owned", 16'h0100, 3'd1);
    send(3, 16'h0100, 3'd1, 3'd0, 4'd0, 32'hE1);
    exp_wr("R7 write2", 16'h0100, 32'hE1);
    mem(1, 16'h0100, 3'd1);
    @(negedge clk);
    exp_rd("R3 replay spec", 16'h0100, 3'd2, 2'd1);
    mem(0, 16'h0100, 3'd2, 32'hC3);
    exp_rsp("R3 spec rsp", 16'h0100, 3'd2, 2'd1, 32'hC3);
  endtask

  task automatic t_spec();
    send(1, 16'h0200, 3'd4);
    exp_rd("R3", 16'h0200, 3'd4, 2'd1);
    mem(0, 16'h0200, 3'd4, 32'h44);
    exp_rsp("R3", 16'h0200, 3'd4, 2'd1, 32'h44);
    send(0, 16'h0200, 3'd5);
    exp_rd("R3 no owner", 16'h0200, 3'd5, 2'd0);
    mem(0, 16'h0200, 3'd5, 32'h55);
    send(3, 16'h0200, 3'd5, 3'd0, 4'd0, 32'h5);
    mem(1, 16'h0200, 3'd5);
  endtask

  task automatic t_expose();
    send(2, 16'h0300, 3'd6, 3'd2, 4'd9);
    exp_rd("R4", 16'h0300, 3'd6, 2'd2);
    check("R4 tags", {mem_rd_origin, mem_rd_idx}, {3'd2, 4'd9});
    mem(0, 16'h0300, 3'd6, 32'h66);
    exp_rsp("R4", 16'h0300, 3'd6, 2'd2, 32'h66);
    send(0, 16'h0300, 3'd0);
    exp_inv("R4 owner", 16'h0300, 3'd6);
    send(3, 16'h0300, 3'd6, 3'd0, 4'd0, 32'h6);
    mem(1, 16'h0300, 3'd6);
    @(negedge clk);
    exp_rd("R7 release", 16'h0300, 3'd0, 2'd0);
    mem(0, 16'h0300, 3'd0, 32'h70);
    send(3, 16'h0300, 3'd0, 3'd0, 4'd0, 32'h7);
    mem(1, 16'h0300, 3'd0);
  endtask

  task automatic t_transient();
    send(2, 16'h0400, 3'd2);
    exp_rd("R4", 16'h0400, 3'd2, 2'd2);
    send(3, 16'h0400, 3'd2, 3'd0, 4'd0, 32'h55);
    quiet("R8 wb held");
    send(1, 16'h0400, 3'd7);
    quiet("R8 spec held");
    send(0, 16'h0500, 3'd4);
    exp_rd("R13", 16'h0500, 3'd4, 2'd0);
    mem(0, 16'h0400, 3'd2, 32'h99);
    exp_rsp("R4", 16'h0400, 3'd2, 2'd2, 32'h99);
    @(negedge clk);
    exp_wr("R8 released wb", 16'h0400, 32'h55);
    @(negedge clk);
    quiet("R8 spec held in writeback");
    mem(0, 16'h0500, 3'd4, 32'h5A);
    exp_rsp("R13", 16'h0500, 3'd4, 2'd0, 32'h5A);
    mem(1, 16'h0400, 3'd2);
    @(negedge clk);
    exp_rd("R9", 16'h0400, 3'd7, 2'd1);
    mem(0, 16'h0400, 3'd7, 32'h77);
    exp_rsp("R3", 16'h0400, 3'd7, 2'd1, 32'h77);
    send(3, 16'h0500, 3'd4, 3'd0, 4'd0, 32'h1);
    mem(1, 16'h0500, 3'd4);
  endtask

  task automatic t_wb_drop();
    send(3, 16'h0600, 3'd1, 3'd0, 4'd0, 32'hDEAD);
    quiet("R12");
    send(0, 16'h0600, 3'd1);
    exp_rd("R12 still untracked", 16'h0600, 3'd1, 2'd0);
    mem(0, 16'h0600, 3'd1, 32'h1);
    send(3, 16'h0600, 3'd1, 3'd0, 4'd0, 32'h2);
    mem(1, 16'h0600, 3'd1);
  endtask

  task automatic t_priority();
    @(negedge clk);
    mem_rsp_valid = 1'b1; mem_rsp_ack = 1'b1; mem_rsp_addr = 16'h0700; mem_rsp_src = 3'd0;
    req_type = 2'd0; req_addr = 16'h0780; req_src = 3'd2; req_valid = 1'b1;
    #1;
    check("R10 ready low", req_ready, 1'b0);
    @(negedge clk);
    quiet("R10 stray reply");
    mem_rsp_valid = 1'b0;
    #1;
    check("R10 ready back", req_ready, 1'b1);
    @(negedge clk);
    req_valid = 1'b0;
    exp_rd("R10", 16'h0780, 3'd2, 2'd0);
  endtask

  task automatic t_buf_full();
    send(0, 16'h0800, 3'd1);
    exp_rd("R2", 16'h0800, 3'd1, 2'd0);
    for (int i = 0; i < 4; i++) begin
      send(0, 16'h0800, 3'(i + 2));
      quiet("R8");
    end
    @(negedge clk);
    req_type = 2'd0; req_addr = 16'h0900; req_valid = 1'b1;
    #1;
    check("R11 buffer full", req_ready, 1'b0);
    req_valid = 1'b0;
  endtask

  task automatic t_table_full();
    do_reset();
    for (int i = 0; i < 8; i++) begin
      send(0, 16'h1000 + 16'(i), 3'd1);
      exp_rd("R2", 16'h1000 + 16'(i), 3'd1, 2'd0);
    end
    @(negedge clk);
    req_type = 2'd0; req_addr = 16'h2000; req_valid = 1'b1;
    #1;
    check("R11 table full", req_ready, 1'b0);
    req_addr = 16'h1003;
    #1;
    check("R11 tracked line", req_ready, 1'b1);
    @(negedge clk);
    req_valid = 1'b0;
    quiet("R8");
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_owned_line();
    t_spec();
    t_expose();
    t_transient();
    t_wb_drop();
    t_priority();
    t_buf_full();
    t_table_full();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule